// File: doc/BRIEF.md
# Randomized Exponential Backoff Timer

This block paces the retries of a requester that spins on a shared lock. Each time an acquire attempt fails, the requester pulses `start_i`. The timer then waits a pseudo-random number of clock cycles and signals the end of the wait with a one-cycle `done_o` pulse. The random delay is always drawn strictly below a current limit. That limit starts at a configured minimum and doubles after every failed attempt, until it reaches a configured maximum. When the requester finally gets the lock, it pulses `success_i`, and the next failure starts again from the minimum.

The random source is an internal 16-bit linear feedback shift register. The delay is formed by masking the register with the limit minus one, so the minimum and maximum delays must be powers of two, with the minimum no larger than the maximum. The block only counts cycles. It does not arbitrate, hold any lock state, or talk to software.

Top module: `backoff_timer`

## Requirements
- R1: After reset, `busy_o` and `done_o` are 0, no backoff is in progress, and the shift register holds 16'hACE1.
- R2: A start is accepted when `start_i` is 1, `busy_o` is 0 and `success_i` is 0 at a rising edge. It draws a delay d = register value AND (limit − 1). For d ≥ 1, `busy_o` is 1 for exactly d cycles after that edge, and `done_o` is 1 in the cycle after the d-th following edge.
- R3: A drawn delay of 0 gives `done_o` in the cycle right after the accepting edge, and `busy_o` stays 0.
- R4: The first accepted start after reset or after a success uses `min_dly_i` as its limit.
- R5: After each draw, the next limit is twice the limit just used if that limit is below `max_dly_i`; otherwise it stays the same. With valid power-of-two settings, the limit never exceeds `max_dly_i`.
- R6: `success_i` returns the block to the not-yet-failed state, so the next draw uses `min_dly_i`. In the same cycle it takes priority over `start_i`: that start is dropped, and it neither draws a delay nor advances the register.
- R7: A `start_i` seen while `busy_o` is 1 is ignored. It does not change the running wait, the limit or the register.
- R8: The register steps as next = {v[14:0], v[15]^v[14]^v[12]^v[3]}. It steps once per accepted start, and the draw uses the value before the step.
- R9: `done_o` is high for a single cycle per accepted start, and `busy_o` and `done_o` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Acquire attempt failed; begin a backoff wait |
| success_i | input | 1 | Lock acquired; return the limit to the minimum |
| min_dly_i | input | DLY_W | Minimum limit (power of two) |
| max_dly_i | input | DLY_W | Maximum limit (power of two, ≥ minimum) |
| busy_o | output | 1 | Wait in progress |
| done_o | output | 1 | One-cycle pulse when the wait ends |

## Verification
The bench models the shift register and the limit from the requirements. It predicts every delay exactly and counts the busy cycles edge by edge.

- **Zero delay.** A design that mishandles this case would raise `busy_o` or lose the pulse. A minimum of 1 forces it.
- **Limit doubling and capping.** An off-by-one in the doubling compare would make later delays exceed or fall short of the predicted values.
- **Stray start while busy.** A design that accepts a stray start would shift the register or the limit, and every later prediction would diverge.
- **Success and start together.** A design that lets the start win would launch a wait or keep the grown limit.

// File: rtl/backoff_pkg.sv
package backoff_pkg;
  localparam int unsigned LFSR_W = 16;
  localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } bo_state_e;

  // x^16 + x^15 + x^13 + x^4 + 1, Fibonacci form
  function automatic logic [LFSR_W-1:0] lfsr_adv(input logic [LFSR_W-1:0] v);
    return {v[LFSR_W-2:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction
endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr
  import backoff_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  output logic [LFSR_W-1:0] val_o
);
  logic [LFSR_W-1:0] state_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    state_q <= LFSR_SEED;
    else if (adv_i) state_q <= lfsr_adv(state_q);
  end

  assign val_o = state_q;
endmodule

// File: rtl/backoff_limit.sv
module backoff_limit #(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             draw_i,
  input  logic             clear_i,
  input  logic [DLY_W-1:0] min_i,
  input  logic [DLY_W-1:0] max_i,
  output logic [DLY_W-1:0] lim_o,
  output logic [DLY_W-1:0] lim_q_o,
  output logic             armed_o
);
  logic             armed_q;
  logic [DLY_W-1:0] lim_q;
  logic [DLY_W-1:0] lim_nxt;

  // limit in force for a draw this cycle
  assign lim_o   = armed_q ? lim_q : min_i;
  assign lim_nxt = (lim_o < max_i) ? {lim_o[DLY_W-2:0], 1'b0} : lim_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      lim_q   <= '0;
    end else if (clear_i) begin
      armed_q <= 1'b0;
    end else if (draw_i) begin
      armed_q <= 1'b1;
      lim_q   <= lim_nxt;
    end
  end

  assign lim_q_o = lim_q;
  assign armed_o = armed_q;
endmodule

// File: rtl/backoff_counter.sv
module backoff_counter
  import backoff_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DLY_W-1:0] dly_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DLY_W-1:0] cnt_o
);
  bo_state_e        st_q;
  logic [DLY_W-1:0] cnt_q;
  logic             done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: begin
          if (load_i) begin
            if (dly_i == '0) begin
              done_q <= 1'b1;
            end else begin
              st_q  <= ST_WAIT;
              cnt_q <= dly_i;
            end
          end
        end
        ST_WAIT: begin
          if (cnt_q == DLY_W'(1)) begin
            st_q   <= ST_IDLE;
            cnt_q  <= '0;
            done_q <= 1'b1;
          end else begin
            cnt_q <= cnt_q - DLY_W'(1);
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign busy_o = (st_q == ST_WAIT);
  assign done_o = done_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/backoff_timer.sv
module backoff_timer
  import backoff_pkg::*;
#(
  parameter int unsigned DLY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             success_i,
  input  logic [DLY_W-1:0] min_dly_i,
  input  logic [DLY_W-1:0] max_dly_i,
  output logic             busy_o,
  output logic             done_o
);
  logic              accept;
  logic [LFSR_W-1:0] rnd_raw;
  logic [DLY_W-1:0]  rnd;
  logic [DLY_W-1:0]  lim;
  logic [DLY_W-1:0]  lim_q;
  logic [DLY_W-1:0]  dly;
  logic [DLY_W-1:0]  cnt;
  logic              armed;

  assign accept = start_i && !busy_o && !success_i;

  backoff_lfsr u_lfsr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (accept),
    .val_o (rnd_raw)
  );

  generate
    if (DLY_W > LFSR_W) begin : g_ext
      assign rnd = {{(DLY_W - LFSR_W){1'b0}}, rnd_raw};
    end else begin : g_trunc
      assign rnd = rnd_raw[DLY_W-1:0];
    end
  endgenerate

  backoff_limit #(.DLY_W(DLY_W)) u_limit (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .draw_i (accept),
    .clear_i(success_i),
    .min_i  (min_dly_i),
    .max_i  (max_dly_i),
    .lim_o  (lim),
    .lim_q_o(lim_q),
    .armed_o(armed)
  );

  // limits are powers of two: mask keeps the draw below the limit
  assign dly = rnd & (lim - DLY_W'(1));

  backoff_counter #(.DLY_W(DLY_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .load_i(accept),
    .dly_i (dly),
    .busy_o(busy_o),
    .done_o(done_o),
    .cnt_o (cnt)
  );
endmodule

// File: rtl/backoff_timer_chk.sv
module backoff_timer_chk #(
  parameter int unsigned DLY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             start_i,
  input logic             success_i,
  input logic             busy_o,
  input logic             done_o,
  input logic             armed,
  input logic [DLY_W-1:0] cnt,
  input logic [DLY_W-1:0] lim_q
);
  // R9
  busy_done_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));

  // R2
  fall_gives_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);

  // R2
  busy_cnt_live_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (cnt != '0));

  // R9
  done_has_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ($past(busy_o) || $past(start_i)));

  // R7
  busy_start_lim_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i) |=> $stable(lim_q));

  // R7
  busy_start_arm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && start_i && !success_i) |=> $stable(armed));

  // R6
  success_disarm_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    success_i |=> !armed);
endmodule

bind backoff_timer backoff_timer_chk #(.DLY_W(DLY_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .success_i(success_i),
  .busy_o   (busy_o),
  .done_o   (done_o),
  .armed    (armed),
  .cnt      (cnt),
  .lim_q    (lim_q)
);

// File: tb/backoff_timer_bench.sv
module backoff_timer_bench;
  localparam int unsigned DLY_W = 16;
  localparam time CLK_PERIOD = 10ns;
  localparam int unsigned WDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic success = 1'b0;
  logic [DLY_W-1:0] min_dly = 16'd4;
  logic [DLY_W-1:0] max_dly = 16'd64;
  logic busy;
  logic done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  logic [15:0] lfsr_m = 16'hACE1;
  bit armed_m = 1'b0;
  logic [DLY_W-1:0] lim_m = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  backoff_timer #(.DLY_W(DLY_W)) u_backoff_timer (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .start_i  (start),
    .success_i(success),
    .min_dly_i(min_dly),
    .max_dly_i(max_dly),
    .busy_o   (busy),
    .done_o   (done)
  );

  function automatic logic [15:0] m_step(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[14] ^ v[12] ^ v[3]};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // one accepted start; predicts delay and walks the wait edge by edge
  task automatic do_start(input bit stray);
    logic [DLY_W-1:0] lu;
    int d;
    string tg;
    @(negedge clk);
    start = 1'b1;
    lu = armed_m ? lim_m : min_dly;
    tg = armed_m ? "R5/R8" : "R4/R8";
    d  = int'(lfsr_m & (lu - 16'd1));
    lfsr_m  = m_step(lfsr_m);
    lim_m   = (lu < max_dly) ? (lu << 1) : lu;
    armed_m = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int j = 0; j < d; j++) begin
      chk(busy === 1'b1 && done === 1'b0, {"R2 busy ", tg}, int'(busy), 1);
      start = stray && (j == 0) && (d >= 2);  // R7 stray start while busy
      @(negedge clk);
    end
    start = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, (d == 0) ? "R3 done" : {"R2 done ", tg},
        int'(done), 1);
    @(negedge clk);
    chk(done === 1'b0, stray ? "R7/R9 pulse" : "R9 pulse", int'(done), 0);
  endtask

  task automatic do_success(input bit with_start);
    @(negedge clk);
    success = 1'b1;
    start   = with_start;
    @(negedge clk);
    success = 1'b0;
    start   = 1'b0;
    armed_m = 1'b0;
    chk(busy === 1'b0 && done === 1'b0, "R6 start dropped", int'(busy | done), 0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 reset outputs", int'(busy | done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 1'b0 && done === 1'b0, "R1 idle after reset", int'(busy | done), 0);

    // directed: growth from 4 up to 64 and held at the cap
    for (int i = 0; i < 7; i++) do_start(i == 2);
    do_success(1'b1);
    do_start(1'b0);          // back to minimum
    // directed: zero delay forced by a limit of 1
    do_success(1'b0);
    min_dly = 16'd1;
    max_dly = 16'd1;
    for (int i = 0; i < 3; i++) do_start(1'b0);
    // directed: min equals max
    do_success(1'b0);
    min_dly = 16'd32;
    max_dly = 16'd32;
    for (int i = 0; i < 3; i++) do_start(1'b1);

    // constrained random
    for (int i = 0; i < 120; i++) begin
      int r;
      r = int'($urandom % 8);
      if (r == 0) begin
        do_success(($urandom % 2) == 1);
        min_dly = 16'd1 << ($urandom % 4);
        max_dly = min_dly << ($urandom % 5);
      end else begin
        do_start(($urandom % 3) == 0);
      end
    end
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < WDOG; c++) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", WDOG, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule